// File: doc/BRIEF.md
# Floating-Point Register Stack with Tags

This block holds the eight wide data registers of a stack-organised floating-point unit, together with the state that goes with them. That state is a 3-bit top pointer, a 16-bit tag word with one 2-bit tag per physical register, a control word, and the flag part of a status word. Every command names a register relative to the current top of stack. The block rotates that index through the top pointer to reach a physical register. It then checks the relevant tags and either carries out the command or takes a fault response.

One command arrives per clock cycle on `cmd_op` / `cmd_idx` and takes effect at the next rising edge. Values are opaque `DATA_W`-bit words. Arithmetic, rounding and decode belong to the surrounding unit. Each cycle a command decoder picks one of these actions:

- push-external, push-copy, push-indefinite
- swap, fill-st0, fill-sti, refuse
- free, free-pop, copy, copy-pop
- init, clear-flags, set-control, idle

A write planner then turns that action into register-file writes, tag updates, and pointer and flag changes. A combinational read port returns any stack slot and its tag.

Top module: `fpstk`

## Requirements
- R1: Reset and the init command (op 7) give tag word 0xFFFF, control word 0x037F, top 0 and status word 0. Reset also zeroes every data word, while init leaves the data words as they are.
- R2: Slot i maps to physical register (top+i) mod 8, and the tag of physical register r sits at tag word bits [2r+1:2r]. Tag codes are 00 valid, 01 zero, 10 special and 11 empty. Status word bits [13:11] always show top.
- R3: Overflow occurs when push-external (op 9) or load (op 1) finds physical register (top-1) mod 8 not empty. It sets status bits 0 (invalid) and 6 (stack fault) and sets bit 9 (C1) to 1. With control bit 0 (invalid mask) at 1, the block pushes the indefinite value with tag 10. With the mask at 0, it also sets bits 7 (summary) and 15 (busy) and changes neither the stack nor top.
- R4: Push-external without overflow decrements top and writes `cmd_data` and `cmd_tag` into the new slot 0.
- R5: Load st(i) with no overflow and st(i) not empty decrements top and writes the old st(i) value and tag into the new slot 0.
- R6: Load st(i) with no overflow and st(i) empty is an underflow. It sets bits 0 and 6 and clears C1. With the mask at 1, it pushes the indefinite value with tag 10. With the mask at 0, it sets bits 7 and 15 and leaves the stack unchanged.
- R7: Exchange (op 2) with st(0) and st(i) both non-empty swaps their values and tags and clears C1.
- R8: Exchange with exactly one empty operand is an underflow (same flags as R6). With the mask at 1, the valid operand's value and tag are copied into the empty slot. With the mask at 0, nothing changes. With both operands empty, only the underflow flags change.
- R9: Free (op 3) sets only st(i)'s tag to 11. Free-pop (op 4) does the same and then pops.
- R10: Store (op 5) copies st(0)'s value and tag into st(i). Store-pop (op 6) does the same and then pops.
- R11: A pop sets the tag of the current st(0) to 11 and increments top mod 8. The pop's tag write overrides any other write to that register in the same cycle.
- R12: Clear-flags (op 8) clears status bits 0-7 and bit 15. It keeps bits 8-10 and 14 (condition codes) and keeps top.
- R13: Set-control (op 10) loads the control word from `cmd_data[15:0]`. Op 0 and ops 11-15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 4 | Command code, one per cycle |
| cmd_idx | input | 3 | Stack-relative register index i |
| cmd_data | input | DATA_W | Value for push-external; bits [15:0] for set-control |
| cmd_tag | input | 2 | Tag for push-external |
| rd_idx | input | 3 | Stack-relative index for the read port |
| rd_data | output | DATA_W | Value of slot rd_idx |
| rd_tag | output | 2 | Tag of slot rd_idx |
| top_ptr | output | 3 | Top-of-stack pointer |
| tag_word | output | 16 | Tags of all physical registers |
| ctrl_word | output | 16 | Control word |
| status_word | output | 16 | Status flags with top in bits [13:11] |

## Verification
The bench builds the block with its defaults: 80-bit data words and the standard indefinite pattern as the fill value. Full-width random words make any mis-routed copy or swap visible in every bit. An indefinite fill is therefore distinguishable from any pushed value. Random command streams toggle the invalid mask and wrap top through all eight positions. This brings overflow, both underflow kinds, self-exchange with index 0 and store-pop onto itself within reach alongside the ordinary paths.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;

    localparam int NREGS = 8;
    localparam int IDX_W = $clog2(NREGS);
    localparam int TAGW_W = 2 * NREGS;

    typedef logic [IDX_W-1:0] idx_t;

    localparam logic [1:0] TAG_EMPTY   = 2'b11;
    localparam logic [1:0] TAG_SPECIAL = 2'b10;

    localparam logic [15:0] CW_INIT   = 16'h037F;
    localparam logic [15:0] CLR_MASK  = 16'h80FF;
    localparam int          SB_INV    = 0;
    localparam int          SB_FAULT  = 6;
    localparam int          SB_SUM    = 7;
    localparam int          SB_C1     = 9;
    localparam int          SB_BUSY   = 15;

    typedef enum logic [3:0] {
        OP_NOP    = 4'd0,
        OP_LOAD   = 4'd1,
        OP_XCHG   = 4'd2,
        OP_FREE   = 4'd3,
        OP_FREEP  = 4'd4,
        OP_STORE  = 4'd5,
        OP_STOREP = 4'd6,
        OP_INIT   = 4'd7,
        OP_CLEX   = 4'd8,
        OP_PUSH   = 4'd9,
        OP_SETCW  = 4'd10
    } op_e;

    typedef enum logic [3:0] {
        ACT_IDLE,
        ACT_PUSH_EXT,
        ACT_PUSH_COPY,
        ACT_PUSH_INDEF,
        ACT_SWAP,
        ACT_FILL_ST0,
        ACT_FILL_STI,
        ACT_REFUSE,
        ACT_FREE,
        ACT_FREE_POP,
        ACT_COPY,
        ACT_COPY_POP,
        ACT_INIT,
        ACT_CLEX,
        ACT_SETCW
    } act_e;

    typedef enum logic [1:0] {
        SRC_ST0,
        SRC_STI,
        SRC_INDEF,
        SRC_EXT
    } src_e;

    typedef enum logic [1:0] {
        FLT_NONE,
        FLT_OVER,
        FLT_UNDER
    } flt_e;

    typedef struct packed {
        logic  wa_en;
        idx_t  wa_reg;
        src_e  wa_src;
        logic  wb_en;
        idx_t  wb_reg;
        src_e  wb_src;
        logic  free_en;
        logic  push;
        logic  pop;
        flt_e  fault;
        logic  clr_c1;
        logic  init;
        logic  clex;
        logic  setcw;
    } plan_t;

endpackage

// File: rtl/fpstk_plan.sv
module fpstk_plan
    import fpstk_pkg::*;
(
    input  logic [3:0]        op_in,
    input  idx_t              idx,
    input  idx_t              top,
    input  logic [TAGW_W-1:0] tags,
    input  logic              inv_masked,
    output plan_t             plan
);

    idx_t       slot_i;
    idx_t       new_top;
    logic [1:0] tag_st0;
    logic [1:0] tag_sti;
    logic [1:0] tag_new;
    act_e       act;
    flt_e       flt;
    logic       clr_c1;

    assign slot_i  = top + idx;
    assign new_top = top - idx_t'(1);
    assign tag_st0 = tags[{top, 1'b0} +: 2];
    assign tag_sti = tags[{slot_i, 1'b0} +: 2];
    assign tag_new = tags[{new_top, 1'b0} +: 2];

    // Action decode: picks what this cycle does and which fault it raises.
    always_comb begin
        act    = ACT_IDLE;
        flt    = FLT_NONE;
        clr_c1 = 1'b0;
        unique case (op_e'(op_in))
            OP_LOAD: begin
                if (tag_new != TAG_EMPTY) begin
                    flt = FLT_OVER;
                    act = inv_masked ? ACT_PUSH_INDEF : ACT_REFUSE;
                end else if (tag_sti == TAG_EMPTY) begin
                    flt = FLT_UNDER;
                    act = inv_masked ? ACT_PUSH_INDEF : ACT_REFUSE;
                end else begin
                    act = ACT_PUSH_COPY;
                end
            end
            OP_PUSH: begin
                if (tag_new != TAG_EMPTY) begin
                    flt = FLT_OVER;
                    act = inv_masked ? ACT_PUSH_INDEF : ACT_REFUSE;
                end else begin
                    act = ACT_PUSH_EXT;
                end
            end
            OP_XCHG: begin
                if (tag_st0 == TAG_EMPTY && tag_sti == TAG_EMPTY) begin
                    flt = FLT_UNDER;
                    act = ACT_REFUSE;
                end else if (tag_st0 == TAG_EMPTY) begin
                    flt = FLT_UNDER;
                    act = inv_masked ? ACT_FILL_ST0 : ACT_REFUSE;
                end else if (tag_sti == TAG_EMPTY) begin
                    flt = FLT_UNDER;
                    act = inv_masked ? ACT_FILL_STI : ACT_REFUSE;
                end else begin
                    act    = ACT_SWAP;
                    clr_c1 = 1'b1;
                end
            end
            OP_FREE:   act = ACT_FREE;
            OP_FREEP:  act = ACT_FREE_POP;
            OP_STORE:  act = ACT_COPY;
            OP_STOREP: act = ACT_COPY_POP;
            OP_INIT:   act = ACT_INIT;
            OP_CLEX:   act = ACT_CLEX;
            OP_SETCW:  act = ACT_SETCW;
            default:   act = ACT_IDLE;
        endcase
    end

    // Write planner: turns the chosen action into register-file work.
    always_comb begin
        plan        = '0;
        plan.wa_reg = top;
        plan.wb_reg = slot_i;
        plan.fault  = flt;
        plan.clr_c1 = clr_c1;
        unique case (act)
            ACT_PUSH_EXT: begin
                plan.wa_en  = 1'b1;
                plan.wa_reg = new_top;
                plan.wa_src = SRC_EXT;
                plan.push   = 1'b1;
            end
            ACT_PUSH_COPY: begin
                plan.wa_en  = 1'b1;
                plan.wa_reg = new_top;
                plan.wa_src = SRC_STI;
                plan.push   = 1'b1;
            end
            ACT_PUSH_INDEF: begin
                plan.wa_en  = 1'b1;
                plan.wa_reg = new_top;
                plan.wa_src = SRC_INDEF;
                plan.push   = 1'b1;
            end
            ACT_SWAP: begin
                plan.wa_en  = 1'b1;
                plan.wa_src = SRC_STI;
                plan.wb_en  = 1'b1;
                plan.wb_src = SRC_ST0;
            end
            ACT_FILL_ST0: begin
                plan.wa_en  = 1'b1;
                plan.wa_src = SRC_STI;
            end
            ACT_FILL_STI: begin
                plan.wb_en  = 1'b1;
                plan.wb_src = SRC_ST0;
            end
            ACT_FREE: plan.free_en = 1'b1;
            ACT_FREE_POP: begin
                plan.free_en = 1'b1;
                plan.pop     = 1'b1;
            end
            ACT_COPY: begin
                plan.wb_en  = 1'b1;
                plan.wb_src = SRC_ST0;
            end
            ACT_COPY_POP: begin
                plan.wb_en  = 1'b1;
                plan.wb_src = SRC_ST0;
                plan.pop    = 1'b1;
            end
            ACT_INIT:  plan.init  = 1'b1;
            ACT_CLEX:  plan.clex  = 1'b1;
            ACT_SETCW: plan.setcw = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/fpstk_regs.sv
module fpstk_regs
    import fpstk_pkg::*;
#(
    parameter int DATA_W = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wa_en,
    input  idx_t              wa_reg,
    input  logic [DATA_W-1:0] wa_data,
    input  logic [1:0]        wa_tag,
    input  logic              wb_en,
    input  idx_t              wb_reg,
    input  logic [DATA_W-1:0] wb_data,
    input  logic [1:0]        wb_tag,
    input  logic              free_en,
    input  idx_t              free_reg,
    input  logic              pop_en,
    input  idx_t              pop_reg,
    input  logic              init_tags,
    output logic [DATA_W-1:0] data_q [NREGS],
    output logic [TAGW_W-1:0] tags_q
);

    for (genvar r = 0; r < NREGS; r++) begin : g_reg
        logic hit_a;
        logic hit_b;
        logic hit_free;
        logic hit_pop;

        assign hit_a    = wa_en   && (wa_reg   == idx_t'(r));
        assign hit_b    = wb_en   && (wb_reg   == idx_t'(r));
        assign hit_free = free_en && (free_reg == idx_t'(r));
        assign hit_pop  = pop_en  && (pop_reg  == idx_t'(r));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_q[r] <= '0;
            end else if (hit_b) begin
                data_q[r] <= wb_data;
            end else if (hit_a) begin
                data_q[r] <= wa_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n || init_tags) begin
                tags_q[2*r +: 2] <= TAG_EMPTY;
            end else if (hit_pop || hit_free) begin
                tags_q[2*r +: 2] <= TAG_EMPTY;
            end else if (hit_b) begin
                tags_q[2*r +: 2] <= wb_tag;
            end else if (hit_a) begin
                tags_q[2*r +: 2] <= wa_tag;
            end
        end
    end

endmodule

// File: rtl/fpstk.sv
module fpstk
    import fpstk_pkg::*;
#(
    parameter int                DATA_W    = 80,
    parameter logic [DATA_W-1:0] INDEF_VAL = 80'hFFFF_C000_0000_0000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        cmd_op,
    input  logic [2:0]        cmd_idx,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [1:0]        cmd_tag,
    input  logic [2:0]        rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic [1:0]        rd_tag,
    output logic [2:0]        top_ptr,
    output logic [15:0]       tag_word,
    output logic [15:0]       ctrl_word,
    output logic [15:0]       status_word
);

    idx_t              top_q;
    logic [15:0]       cw_q;
    logic [15:0]       sw_q;
    logic [15:0]       sw_next;
    plan_t             plan;
    logic [DATA_W-1:0] reg_data [NREGS];
    logic [TAGW_W-1:0] tags_q;
    idx_t              slot_i;
    idx_t              slot_rd;
    logic [DATA_W-1:0] st0_val;
    logic [DATA_W-1:0] sti_val;
    logic [1:0]        st0_tag;
    logic [1:0]        sti_tag;
    logic [DATA_W-1:0] wa_data;
    logic [DATA_W-1:0] wb_data;
    logic [1:0]        wa_tag;
    logic [1:0]        wb_tag;

    assign slot_i  = top_q + cmd_idx;
    assign slot_rd = top_q + rd_idx;
    assign st0_val = reg_data[top_q];
    assign sti_val = reg_data[slot_i];
    assign st0_tag = tags_q[{top_q, 1'b0} +: 2];
    assign sti_tag = tags_q[{slot_i, 1'b0} +: 2];

    fpstk_plan u_plan (
        .op_in      (cmd_op),
        .idx        (cmd_idx),
        .top        (top_q),
        .tags       (tags_q),
        .inv_masked (cw_q[0]),
        .plan       (plan)
    );

    // Operand source selection for the two write ports.
    always_comb begin
        unique case (plan.wa_src)
            SRC_ST0:   begin wa_data = st0_val;   wa_tag = st0_tag;     end
            SRC_STI:   begin wa_data = sti_val;   wa_tag = sti_tag;     end
            SRC_INDEF: begin wa_data = INDEF_VAL; wa_tag = TAG_SPECIAL; end
            default:   begin wa_data = cmd_data;  wa_tag = cmd_tag;     end
        endcase
        unique case (plan.wb_src)
            SRC_ST0:   begin wb_data = st0_val;   wb_tag = st0_tag;     end
            SRC_STI:   begin wb_data = sti_val;   wb_tag = sti_tag;     end
            SRC_INDEF: begin wb_data = INDEF_VAL; wb_tag = TAG_SPECIAL; end
            default:   begin wb_data = cmd_data;  wb_tag = cmd_tag;     end
        endcase
    end

    fpstk_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wa_en     (plan.wa_en),
        .wa_reg    (plan.wa_reg),
        .wa_data   (wa_data),
        .wa_tag    (wa_tag),
        .wb_en     (plan.wb_en),
        .wb_reg    (plan.wb_reg),
        .wb_data   (wb_data),
        .wb_tag    (wb_tag),
        .free_en   (plan.free_en),
        .free_reg  (slot_i),
        .pop_en    (plan.pop),
        .pop_reg   (top_q),
        .init_tags (plan.init),
        .data_q    (reg_data),
        .tags_q    (tags_q)
    );

    // Next status flags.
    always_comb begin
        sw_next = sw_q;
        if (plan.clex) begin
            sw_next = sw_q & ~CLR_MASK;
        end
        if (plan.clr_c1) begin
            sw_next[SB_C1] = 1'b0;
        end
        if (plan.fault != FLT_NONE) begin
            sw_next[SB_INV]   = 1'b1;
            sw_next[SB_FAULT] = 1'b1;
            sw_next[SB_C1]    = (plan.fault == FLT_OVER);
            if (!cw_q[0]) begin
                sw_next[SB_SUM]  = 1'b1;
                sw_next[SB_BUSY] = 1'b1;
            end
        end
    end

    // Architectural state register.
    always_ff @(posedge clk) begin
        if (!rst_n || plan.init) begin
            top_q <= '0;
            cw_q  <= CW_INIT;
            sw_q  <= '0;
        end else begin
            if (plan.push) begin
                top_q <= top_q - idx_t'(1);
            end else if (plan.pop) begin
                top_q <= top_q + idx_t'(1);
            end
            if (plan.setcw) begin
                cw_q <= cmd_data[15:0];
            end
            sw_q <= sw_next;
        end
    end

    assign rd_data     = reg_data[slot_rd];
    assign rd_tag      = tags_q[{slot_rd, 1'b0} +: 2];
    assign top_ptr     = top_q;
    assign tag_word    = tags_q;
    assign ctrl_word   = cw_q;
    assign status_word = {sw_q[15:14], top_q, sw_q[10:0]};

endmodule

// File: rtl/fpstk_chk.sv
module fpstk_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  cmd_op,
    input logic [2:0]  cmd_idx,
    input logic [2:0]  top_ptr,
    input logic [15:0] tag_word,
    input logic [15:0] ctrl_word,
    input logic [15:0] status_word
);

    logic [2:0] below;
    logic [2:0] sel;
    logic       ovf;
    logic       both_full;

    assign below     = top_ptr - 3'd1;
    assign sel       = top_ptr + cmd_idx;
    assign ovf       = tag_word[{below, 1'b0} +: 2] != 2'b11;
    assign both_full = tag_word[{top_ptr, 1'b0} +: 2] != 2'b11
                    && tag_word[{sel, 1'b0} +: 2] != 2'b11;

    // R1
    a_r1_init_state: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_op == 4'd7 |=> tag_word == 16'hFFFF && ctrl_word == 16'h037F
                           && top_ptr == 3'd0 && status_word == 16'h0000);

    // R2
    a_r2_top_in_status: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_op == 4'd0 |=> status_word[13:11] == $past(top_ptr));

    // R3
    a_r3_no_overflow_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 4'd9 && ovf && !ctrl_word[0]) |=>
            $stable(top_ptr) && $stable(tag_word)
            && status_word[6] && status_word[7] && status_word[9]);

    // R3
    a_r3_no_overflow_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 4'd9 && ovf && ctrl_word[0]) |=>
            top_ptr == $past(top_ptr) - 3'd1 && status_word[9] && status_word[0]);

    // R7
    a_r7_swap_keeps_tags: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op == 4'd2 && both_full) |=>
            $countones(tag_word) == $countones($past(tag_word)) && !status_word[9]);

    // R9
    a_r9_free_keeps_top: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_op == 4'd3 |=> $stable(top_ptr) && $stable(status_word));

    // R11
    a_r11_pop_advances: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_op == 4'd4 |=> top_ptr == $past(top_ptr) + 3'd1);

    // R12
    a_r12_clear_flags: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_op == 4'd8 |=> (status_word & 16'h80FF) == 16'h0000
                           && status_word[14:8] == $past(status_word[14:8]));

    // R13
    a_r13_unused_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_op >= 4'd11 |=> $stable(tag_word) && $stable(top_ptr)
                            && $stable(ctrl_word) && $stable(status_word));

endmodule

bind fpstk fpstk_chk u_chk (.*);

// File: tb/test_fpstk.sv
`timescale 1ns/100ps
module test_fpstk;

    localparam logic [79:0] INDEF = 80'hFFFF_C000_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cmd_op = '0;
    logic [2:0]  cmd_idx = '0;
    logic [79:0] cmd_data = '0;
    logic [1:0]  cmd_tag = '0;
    logic [2:0]  rd_idx = '0;
    logic [79:0] rd_data;
    logic [1:0]  rd_tag;
    logic [2:0]  top_ptr;
    logic [15:0] tag_word;
    logic [15:0] ctrl_word;
    logic [15:0] status_word;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [79:0] m_data [8];
    logic [1:0]  m_tag [8];
    logic [2:0]  m_top;
    logic [15:0] m_cw;
    logic [15:0] m_sw;

    always #2 clk = ~clk;

    fpstk i_fpstk (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
        .cmd_data(cmd_data), .cmd_tag(cmd_tag), .rd_idx(rd_idx),
        .rd_data(rd_data), .rd_tag(rd_tag), .top_ptr(top_ptr),
        .tag_word(tag_word), .ctrl_word(ctrl_word), .status_word(status_word)
    );

    task automatic chk(string req, string what, logic [79:0] act, logic [79:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(logic [3:0] op);
        case (op)
            4'd1:    return "R5/R6/R3";
            4'd2:    return "R7/R8";
            4'd3:    return "R9";
            4'd4:    return "R9/R11";
            4'd5:    return "R10";
            4'd6:    return "R10/R11";
            4'd7:    return "R1";
            4'd8:    return "R12";
            4'd9:    return "R4/R3";
            default: return "R13";
        endcase
    endfunction

    function automatic logic [15:0] m_tagword();
        logic [15:0] w;
        for (int r = 0; r < 8; r++) w[2*r +: 2] = m_tag[r];
        return w;
    endfunction

    task automatic m_fault(bit over);
        m_sw[0] = 1'b1;
        m_sw[6] = 1'b1;
        m_sw[9] = over;
        if (!m_cw[0]) begin
            m_sw[7]  = 1'b1;
            m_sw[15] = 1'b1;
        end
    endtask

    task automatic m_push(logic [79:0] v, logic [1:0] t);
        logic [2:0] n;
        n = m_top - 3'd1;
        m_data[n] = v;
        m_tag[n]  = t;
        m_top     = n;
    endtask

    task automatic m_pop();
        m_tag[m_top] = 2'b11;
        m_top = m_top + 3'd1;
    endtask

    task automatic m_apply(logic [3:0] op, logic [2:0] idx, logic [79:0] d, logic [1:0] t);
        logic [2:0] a;
        logic [2:0] b;
        logic [2:0] n;
        logic [79:0] va;
        logic [1:0]  ta;
        a = m_top;
        b = m_top + idx;
        n = m_top - 3'd1;
        case (op)
            4'd1: begin
                if (m_tag[n] != 2'b11) begin
                    m_fault(1'b1);
                    if (m_cw[0]) m_push(INDEF, 2'b10);
                end else if (m_tag[b] == 2'b11) begin
                    m_fault(1'b0);
                    if (m_cw[0]) m_push(INDEF, 2'b10);
                end else begin
                    m_push(m_data[b], m_tag[b]);
                end
            end
            4'd9: begin
                if (m_tag[n] != 2'b11) begin
                    m_fault(1'b1);
                    if (m_cw[0]) m_push(INDEF, 2'b10);
                end else begin
                    m_push(d, t);
                end
            end
            4'd2: begin
                if (m_tag[a] == 2'b11 && m_tag[b] == 2'b11) begin
                    m_fault(1'b0);
                end else if (m_tag[a] == 2'b11) begin
                    m_fault(1'b0);
                    if (m_cw[0]) begin m_data[a] = m_data[b]; m_tag[a] = m_tag[b]; end
                end else if (m_tag[b] == 2'b11) begin
                    m_fault(1'b0);
                    if (m_cw[0]) begin m_data[b] = m_data[a]; m_tag[b] = m_tag[a]; end
                end else begin
                    va = m_data[a]; ta = m_tag[a];
                    m_data[a] = m_data[b]; m_tag[a] = m_tag[b];
                    m_data[b] = va; m_tag[b] = ta;
                    m_sw[9] = 1'b0;
                end
            end
            4'd3: m_tag[b] = 2'b11;
            4'd4: begin m_tag[b] = 2'b11; m_pop(); end
            4'd5: begin m_data[b] = m_data[a]; m_tag[b] = m_tag[a]; end
            4'd6: begin m_data[b] = m_data[a]; m_tag[b] = m_tag[a]; m_pop(); end
            4'd7: begin
                for (int r = 0; r < 8; r++) m_tag[r] = 2'b11;
                m_cw = 16'h037F; m_top = '0; m_sw = '0;
            end
            4'd8: m_sw = m_sw & ~16'h80FF;
            4'd10: m_cw = d[15:0];
            default: ;
        endcase
    endtask

    task automatic check_all(string req);
        chk(req, "top_ptr", 80'(top_ptr), 80'(m_top));
        chk(req, "tag_word", 80'(tag_word), 80'(m_tagword()));
        chk(req, "ctrl_word", 80'(ctrl_word), 80'(m_cw));
        chk(req, "status_word", 80'(status_word), 80'({m_sw[15:14], m_top, m_sw[10:0]}));
        for (int k = 0; k < 8; k++) begin
            logic [2:0] p;
            p = m_top + k[2:0];
            rd_idx = k[2:0];
            #0.2;
            chk({req, " R2"}, "rd_data", rd_data, m_data[p]);
            chk({req, " R2"}, "rd_tag", 80'(rd_tag), 80'(m_tag[p]));
        end
    endtask

    task automatic run_cmd(logic [3:0] op, logic [2:0] idx, logic [79:0] d, logic [1:0] t);
        cmd_op = op; cmd_idx = idx; cmd_data = d; cmd_tag = t;
        @(posedge clk);
        #1;
        m_apply(op, idx, d, t);
        check_all(req_of(op));
    endtask

    function automatic logic [79:0] rnd80();
        return {16'($urandom), $urandom, $urandom};
    endfunction

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements): run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int r = 0; r < 8; r++) begin m_data[r] = '0; m_tag[r] = 2'b11; end
        m_top = '0; m_cw = 16'h037F; m_sw = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #0.5;
        check_all("R1");

        // Directed: unmasked faults on a full stack.
        run_cmd(4'd10, 3'd0, 80'h0370, 2'b00);
        for (int k = 0; k < 8; k++) run_cmd(4'd9, 3'd0, rnd80(), 2'(k % 3));
        run_cmd(4'd9, 3'd0, rnd80(), 2'b00);   // R3 refused overflow
        run_cmd(4'd1, 3'd2, '0, 2'b00);        // R3 via load
        run_cmd(4'd8, 3'd0, '0, 2'b00);        // R12 keeps C1
        run_cmd(4'd2, 3'd5, '0, 2'b00);        // R7 swap
        run_cmd(4'd4, 3'd7, '0, 2'b00);        // R9 free-pop
        run_cmd(4'd1, 3'd6, '0, 2'b00);        // R6 refused underflow
        run_cmd(4'd2, 3'd7, '0, 2'b00);        // R8 one empty, refused
        run_cmd(4'd6, 3'd0, '0, 2'b00);        // R10 store-pop onto itself
        run_cmd(4'd12, 3'd3, rnd80(), 2'b01);  // R13 unused code
        // Directed: masked responses.
        run_cmd(4'd7, 3'd0, '0, 2'b00);        // R1 init keeps data
        run_cmd(4'd2, 3'd0, '0, 2'b00);        // R8 both empty
        run_cmd(4'd1, 3'd3, '0, 2'b00);        // R6 masked indefinite
        run_cmd(4'd2, 3'd1, '0, 2'b00);        // R8 masked fill st(i)
        run_cmd(4'd3, 3'd0, '0, 2'b00);        // R9 free st0
        run_cmd(4'd2, 3'd1, '0, 2'b00);        // R8 masked fill st0
        for (int k = 0; k < 8; k++) run_cmd(4'd9, 3'd0, rnd80(), 2'b00);
        run_cmd(4'd9, 3'd0, rnd80(), 2'b01);   // R3 masked overflow
        run_cmd(4'd5, 3'd4, '0, 2'b00);        // R10 store

        for (int s = 0; s < 2500; s++) begin
            int unsigned r;
            logic [3:0] op;
            logic [79:0] d;
            r = $urandom % 100;
            d = rnd80();
            if (r < 25)      op = 4'd9;
            else if (r < 37) op = 4'd1;
            else if (r < 50) op = 4'd2;
            else if (r < 57) op = 4'd3;
            else if (r < 63) op = 4'd4;
            else if (r < 71) op = 4'd5;
            else if (r < 78) op = 4'd6;
            else if (r < 80) op = 4'd7;
            else if (r < 85) op = 4'd8;
            else if (r < 91) op = 4'd10;
            else if (r < 95) op = 4'd0;
            else             op = 4'(11 + ($urandom % 5));
            run_cmd(op, 3'($urandom), d, 2'($urandom % 3));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule